// File: doc/BRIEF.md
# Multi-Phase Selectable Clock Divider

This block turns one fast oscillator clock into a set of slower square-wave clocks. Four main outputs share one frequency: the fast clock divided by four or by eight, picked by a single divide-select pin. A two-bit phase code sets where each of the four main outputs sits relative to output 0. The offsets are either a whole fast-clock period or a quarter of the output period. Two derived clocks come with them. A half-rate clock rises together with output 0. A double-rate clock copies output 0 when dividing by four and runs at the fast clock divided by four when dividing by eight.

A single counter, clocked by the fast clock, runs over one half-rate period. Every output is decoded from that counter at a fixed offset and driven from a flop, so all outputs are glitch-free and share one clock edge. The divide and phase selects are taken in only at the end of a half-rate period. A change made mid-period therefore never cuts a pulse short. All pins are plain control and clock pins. There is no streaming data path, so no valid/ready handshake is needed.

Top module: `multiphase_clkdiv`

## Requirements
- R1: With div_sel = 0, clk_ph[0] has a period of 4 fast cycles: high for 2 cycles, then low for 2.
- R2: With div_sel = 1, clk_ph[0] has a period of 8 fast cycles: high for 4 cycles, then low for 4.
- R3: With ph_sel = 2'b00, all four clk_ph bits are equal in every cycle.
- R4: With ph_sel = 2'b01, clk_ph[k] lags clk_ph[0] by k quarter periods. A quarter period is 1 fast cycle when dividing by 4 and 2 fast cycles when dividing by 8.
- R5: With ph_sel = 2'b10, clk_ph[1] leads clk_ph[0] by one fast cycle, clk_ph[2] lags it by one fast cycle, and clk_ph[3] lags it by a quarter period.
- R6: With ph_sel = 2'b11, clk_ph[k] lags clk_ph[k-1] by one fast cycle for k = 1, 2, 3.
- R7: clk_half is a 50 percent square wave with twice the period of clk_ph[0], and each of its rising edges coincides with a rising edge of clk_ph[0].
- R8: clk_dbl equals clk_ph[0] when div_sel = 0. When div_sel = 1 it is a 50 percent square wave with a 4-cycle period whose rising edges include every rising edge of clk_ph[0].
- R9: While rst is high, all six outputs are low. On the first fast-clock edge after rst falls, clk_ph[0] and clk_half both go high.
- R10: div_sel and ph_sel are sampled only on the edge that ends a half-rate period (and on the first edge after reset). A change at any other time has no effect on the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 1 | 0 divides by 4, 1 divides by 8 |
| ph_sel | input | 2 | Phase relationship code for clk_ph[3:0] |
| clk_ph | output | 4 | Four equal-frequency phased clocks |
| clk_half | output | 1 | Half-rate clock aligned with clk_ph[0] |
| clk_dbl | output | 1 | Double-rate clock (mode dependent) |

## Verification
The bench builds the block with its default parameters: four phased outputs and a 4-bit counter that covers the 16-cycle half-rate period of divide-by-8. It walks all eight combinations of divide mode and phase code. This exercises both quarter-period sizes and the wrap of the one-cycle lead for output 1 across the counter boundary. The select pins change at arbitrary cycles, so many changes land mid-period and the hold-until-wrap rule is tested. A second reset in the middle of the run checks start-up alignment again, this time from divide-by-8.

// File: rtl/mpcd_pkg.sv
package mpcd_pkg;
  localparam int NUM_PH = 4;
  localparam int MAX_DIV = 8;
  localparam int CNT_W = $clog2(2 * MAX_DIV);

  typedef enum logic [1:0] {
    PH_ALIGN   = 2'b00,
    PH_QUAD    = 2'b01,
    PH_EARLYLT = 2'b10,
    PH_CASCADE = 2'b11
  } ph_code_e;

  // Offset (in fast cycles, modulo 2^CNT_W) of phased output k behind output 0.
  function automatic logic [CNT_W-1:0] ph_offset(input logic [1:0] code,
                                                 input int k,
                                                 input logic div8);
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] kk;
    quarter = div8 ? CNT_W'(2) : CNT_W'(1);
    kk = CNT_W'(k);
    case (ph_code_e'(code))
      PH_ALIGN:   ph_offset = '0;
      PH_QUAD:    ph_offset = kk * quarter;
      PH_EARLYLT: begin
        if (k == 1)      ph_offset = '1;           // one cycle early
        else if (k == 2) ph_offset = CNT_W'(1);    // one cycle late
        else if (k == 3) ph_offset = quarter;
        else             ph_offset = '0;
      end
      default:    ph_offset = kk;
    endcase
  endfunction
endpackage

// File: rtl/mpcd_seq.sv
module mpcd_seq
  import mpcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             div_sel,
  input  logic [1:0]       ph_sel,
  output logic [CNT_W-1:0] cnt_n,
  output logic             mode_n,
  output logic [1:0]       sel_n,
  output logic             mode_q,
  output logic [1:0]       sel_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  // End of half-rate period: 8 cycles when dividing by 4, 16 when dividing by 8.
  assign wrap = (cnt_q[CNT_W-2:0] == '1) && (!mode_q || cnt_q[CNT_W-1]);

  always_comb begin
    if (wrap) begin
      cnt_n  = '0;
      mode_n = div_sel;
      sel_n  = ph_sel;
    end else begin
      cnt_n  = cnt_q + CNT_W'(1);
      mode_n = mode_q;
      sel_n  = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;          // forces a wrap on the first edge after release
      mode_q <= 1'b0;
      sel_q  <= 2'b00;
    end else begin
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
      sel_q  <= sel_n;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(sel_q) && $stable(mode_q))); // R10
endmodule

// File: rtl/mpcd_dec.sv
module mpcd_dec
  import mpcd_pkg::*;
(
  input  logic [CNT_W-1:0]  cnt,
  input  logic              div8,
  input  logic [1:0]        code,
  output logic [NUM_PH-1:0] ph,
  output logic              half,
  output logic              dbl
);
  logic [CNT_W-1:0] pmask;
  assign pmask = div8 ? CNT_W'(7) : CNT_W'(3);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    logic [CNT_W-1:0] phase;
    assign phase = (cnt - ph_offset(code, k, div8)) & pmask;
    assign ph[k] = div8 ? ~phase[2] : ~phase[1];
  end

  assign half = div8 ? ~cnt[3] : ~cnt[2];
  assign dbl  = div8 ? ~cnt[1] : ph[0];
endmodule

// File: rtl/multiphase_clkdiv.sv
module multiphase_clkdiv
  import mpcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              div_sel,
  input  logic [1:0]        ph_sel,
  output logic [NUM_PH-1:0] clk_ph,
  output logic              clk_half,
  output logic              clk_dbl
);
  logic [CNT_W-1:0]  cnt_n;
  logic              mode_n, mode_q;
  logic [1:0]        sel_n, sel_q;
  logic [NUM_PH-1:0] ph_d;
  logic              half_d, dbl_d;

  mpcd_seq u_seq (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
    .cnt_n(cnt_n), .mode_n(mode_n), .sel_n(sel_n),
    .mode_q(mode_q), .sel_q(sel_q)
  );

  mpcd_dec u_dec (
    .cnt(cnt_n), .div8(mode_n), .code(sel_n),
    .ph(ph_d), .half(half_d), .dbl(dbl_d)
  );

  // Outputs come straight from flops so every clock edge is glitch-free.
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ph   <= '0;
      clk_half <= 1'b0;
      clk_dbl  <= 1'b0;
    end else begin
      clk_ph   <= ph_d;
      clk_half <= half_d;
      clk_dbl  <= dbl_d;
    end
  end

  AST_RST_LOW: assert property (@(posedge clk)
    rst |=> (clk_ph == '0 && !clk_half && !clk_dbl)); // R9
  AST_ALIGN_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'b00) |-> (clk_ph == '0 || clk_ph == '1)); // R3
  AST_HALF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_half) |-> clk_ph[0]); // R7
  AST_DBL_DIV4: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (clk_dbl == clk_ph[0])); // R8
endmodule

// File: tb/sim_multiphase_clkdiv.sv
module sim_multiphase_clkdiv;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_sel = 1'b0;
  logic [1:0] ph_sel = 2'b00;
  logic [3:0] clk_ph;
  logic       clk_half, clk_dbl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [5:0] exp;   // {dbl, half, ph[3:0]}
    string      r_out0;
    string      r_ph;
    string      r_half;
    string      r_dbl;
  } item_t;
  item_t sb[$];

  multiphase_clkdiv u0 (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
    .clk_ph(clk_ph), .clk_half(clk_half), .clk_dbl(clk_dbl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Reference state built from the requirements.
  int   mc = 15;
  bit   pend = 1;
  logic mmode = 0;
  logic [1:0] msel = 0;

  function automatic int offs(input logic [1:0] s, input int k, input logic m);
    int q = m ? 2 : 1;
    case (s)
      2'b00: return 0;
      2'b01: return k * q;                               // R4
      2'b10: return (k == 1) ? -1 : (k == 2) ? 1 : (k == 3) ? q : 0; // R5
      default: return k;                                 // R6
    endcase
  endfunction

  task automatic drive_expect();
    item_t it;
    bit first;
    int p, hp;
    if (rst) begin
      pend = 1; mc = 15; mmode = 0; msel = 0;
      it.exp = '0;
      it.r_out0 = "R9"; it.r_ph = "R9"; it.r_half = "R9"; it.r_dbl = "R9";
      sb.push_back(it);
      return;
    end
    first = pend;
    hp = mmode ? 16 : 8;
    if (pend || mc == hp - 1) begin
      mmode = div_sel; msel = ph_sel; mc = 0; pend = 0;
    end else begin
      mc++;
    end
    p = mmode ? 8 : 4;
    for (int k = 0; k < 4; k++)
      it.exp[k] = (((mc - offs(msel, k, mmode)) % p + p) % p) < p / 2;
    it.exp[4] = (mc % (2 * p)) < p;                       // R7
    it.exp[5] = mmode ? ((mc % 4) < 2) : it.exp[0];      // R8
    it.r_out0 = mmode ? "R2" : "R1";
    case (msel)
      2'b00: it.r_ph = "R3";
      2'b01: it.r_ph = "R4";
      2'b10: it.r_ph = "R5";
      default: it.r_ph = "R6";
    endcase
    it.r_half = "R7";
    it.r_dbl = "R8";
    if (first) begin
      it.r_out0 = "R9"; it.r_half = "R9";
    end else if (div_sel != mmode || ph_sel != msel) begin
      it.r_out0 = "R10"; it.r_ph = "R10"; it.r_half = "R10"; it.r_dbl = "R10";
    end
    sb.push_back(it);
  endtask

  // Driver: one expected item per fast-clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      drive_expect();
    end
  end

  // Monitor: compare away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it = sb.pop_front();
        act = {clk_dbl, clk_half, clk_ph};
        check(act[0] === it.exp[0], it.r_out0, "clk_ph[0]", act, it.exp);
        check(act[3:1] === it.exp[3:1], it.r_ph, "clk_ph[3:1]", act, it.exp);
        check(act[4] === it.exp[4], it.r_half, "clk_half", act, it.exp);
        check(act[5] === it.exp[5], it.r_dbl, "clk_dbl", act, it.exp);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(5);
    rst = 0;
    run(37);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        div_sel = m[0];
        ph_sel = 2'(s);
        run(45 + 3 * s);     // odd lengths land changes mid-period (R10)
      end
    end
    rst = 1;                 // second reset, restarting in divide-by-8 (R9)
    div_sel = 1; ph_sel = 2'b10;
    run(3);
    rst = 0;
    run(50);
    ph_sel = 2'b01; run(7);
    div_sel = 0; run(40);
    run(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule